// File: doc/BRIEF.md
# Doorbell and Message Register Unit

This block is a small register file that lets a remote host and a local processor hand control and data to each other through interrupts. The host reaches it through a simple slave register port and the local processor through a local register port. Each side can ring a 32-bit doorbell toward the other and can leave 32-bit messages in two message registers per direction. Every doorbell bit and every message write raises an interrupt on the receiving side. The receiving side then acknowledges by writing ones, either to the doorbell bits or to per-message pending flags.

A control bit on the local side switches the unit between its normal mode and an extended doorbell mode that serves two local processors. In extended mode the normal doorbells, messages and their interrupts are frozen and quiet. Each local processor then owns a 32-bit set/clear doorbell that the other one rings. Both register ports have a read latency of one cycle. All interrupt outputs are registered and change on the same clock edge as the register write that causes them.

Top module: `dbmu_top`

## Requirements
- R1: After reset all doorbells, messages, pending flags and masks are zero, the enable bit (local offset 8, bit 0) is 1, `lcl_irq` is 0, `host_irq_n` is 1 and `xirq` is 0.
- R2: A host write to host offset 0 sets the inbound doorbell bits written as 1. The local side reads these bits at local offset 0, and `lcl_irq` rises on the write edge when any unmasked bit is set.
- R3: A local write to local offset 0 clears the inbound doorbell bits written as 1, and zeros have no effect. When the host sets and the local side clears the same bit in one cycle, the set wins.
- R4: A local write to local offset 1 sets the outbound doorbell bits written as 1, the host reads them at host offset 1, and `host_irq_n` goes low on the write edge.
- R5: A host write to host offset 1 clears only the outbound doorbell bits written as 1. `host_irq_n` returns high once no unmasked source is left.
- R6: A host write to host offset 2+i (i = 0, 1) stores inbound message i, which both sides read at offset 2+i. The write sets bit i of the local status register (local offset 6) and raises `lcl_irq`. Local writes to these offsets are ignored.
- R7: A local write to local offset 4+i stores outbound message i, which both sides read at offset 4+i. The write sets bit i of the host status register (host offset 6) and drives `host_irq_n` low. Host writes to these offsets are ignored.
- R8: In each status register, bits 0 and 1 are write-one-to-clear message pending flags, and writing 0 leaves them unchanged. Bit 2 reads 1 while the incoming doorbell of that side is nonzero.
- R9: A mask register at offset 7 on each side uses the status bit layout, where 1 masks that source. It blocks the interrupt without altering the status bits, and the interrupt reappears when the mask is removed.
- R10: While the enable bit is 0, `lcl_irq` is 0 and `host_irq_n` is 1. Writes to doorbell, message and status offsets from either side are ignored, but their contents stay readable.
- R11: Local offsets 9/10 set/clear the processor 0 extended doorbell and offsets 11/12 set/clear the processor 1 extended doorbell, by writing ones. Both offsets of a pair read the doorbell. `xirq[p]` is 1 while doorbell p is nonzero and the unit is disabled. While the unit is enabled, writes to these offsets are ignored and `xirq` is 0.
- R12: A read returns data one cycle after it is presented. A read in the same cycle as a write to the same register returns the value before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_en | input | 1 | Local port access strobe |
| loc_we | input | 1 | Local port write (1) or read (0) |
| loc_addr | input | AW | Local port word offset |
| loc_wdata | input | DW | Local port write data |
| loc_rdata | output | DW | Local port read data, one cycle after the read |
| host_en | input | 1 | Host port access strobe |
| host_we | input | 1 | Host port write (1) or read (0) |
| host_addr | input | AW | Host port word offset |
| host_wdata | input | DW | Host port write data |
| host_rdata | output | DW | Host port read data, one cycle after the read |
| lcl_irq | output | 1 | Interrupt to the local processor, active high |
| host_irq_n | output | 1 | Interrupt to the remote host, active low |
| xirq | output | NPROC | Extended doorbell interrupt per local processor |

## Verification
The hardest situation to reach is a collision: the host sets an inbound doorbell bit in the same cycle that the local side clears it, or a register is read in the cycle it is written. The bench has a task that drives both ports on one clock edge, so it can check that the set wins and that the read returns the old value. The extended mode is only reachable by clearing the enable bit first. The bench therefore writes the extended registers while enabled, then again while disabled, then re-enables the unit with a bit still set, and confirms that `xirq` is silent at each step where it must be.

// File: rtl/dbmu_pkg.sv
package dbmu_pkg;

  // Word offsets shared by both ports; message and later offsets
  // follow from the number of message registers per direction.
  localparam int unsigned OFS_IDB = 0;
  localparam int unsigned OFS_ODB = 1;
  localparam int unsigned OFS_IMSG = 2;

  function automatic int unsigned ofs_omsg(int unsigned nmsg);
    return OFS_IMSG + nmsg;
  endfunction

  function automatic int unsigned ofs_stat(int unsigned nmsg);
    return OFS_IMSG + 2 * nmsg;
  endfunction

  function automatic int unsigned ofs_mask(int unsigned nmsg);
    return OFS_IMSG + 2 * nmsg + 1;
  endfunction

  function automatic int unsigned ofs_ctrl(int unsigned nmsg);
    return OFS_IMSG + 2 * nmsg + 2;
  endfunction

  // Extended doorbells: processor p set at base+2p, clear at base+2p+1
  function automatic int unsigned ofs_xdb(int unsigned nmsg);
    return OFS_IMSG + 2 * nmsg + 3;
  endfunction

endpackage

// File: rtl/dbmu_bitreg.sv
// Doorbell storage: bits set by one write source, cleared by another.
// A set and a clear of the same bit in one cycle leaves the bit set.
module dbmu_bitreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);

  assign nxt_o = (q_o & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= nxt_o;
  end

endmodule

// File: rtl/dbmu_msgbank.sv
// Message registers of one direction with their pending flags.
module dbmu_msgbank #(
  parameter int unsigned DW = 32,
  parameter int unsigned N  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         wr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [N-1:0]         clr_i,
  output logic [N-1:0][DW-1:0] data_o,
  output logic [N-1:0]         pend_o,
  output logic [N-1:0]         pend_nxt_o
);

  assign pend_nxt_o = (pend_o & ~clr_i) | wr_i;

  always_ff @(posedge clk) begin
    if (rst) pend_o <= '0;
    else     pend_o <= pend_nxt_o;
  end

  for (genvar i = 0; i < N; i++) begin : g_msg
    always_ff @(posedge clk) begin
      if (rst)        data_o[i] <= '0;
      else if (wr_i[i]) data_o[i] <= wdata_i;
    end
  end

endmodule

// File: rtl/dbmu_irq.sv
// Registered interrupt from next-state sources, so the output moves on
// the same edge as the register write that causes it.
module dbmu_irq #(
  parameter int unsigned N          = 1,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_nxt_i,
  input  logic [N-1:0] mask_nxt_i,
  input  logic         enable_nxt_i,
  output logic         irq_o
);

  logic hit;
  assign hit = enable_nxt_i & (|(src_nxt_i & ~mask_nxt_i));

  if (ACTIVE_LOW) begin : g_low
    always_ff @(posedge clk) begin
      if (rst) irq_o <= 1'b1;
      else     irq_o <= ~hit;
    end
  end else begin : g_high
    always_ff @(posedge clk) begin
      if (rst) irq_o <= 1'b0;
      else     irq_o <= hit;
    end
  end

endmodule

// File: rtl/dbmu_top.sv
module dbmu_top #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NMSG  = 2,
  parameter int unsigned NPROC = 2,
  parameter int unsigned AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loc_en,
  input  logic             loc_we,
  input  logic [AW-1:0]    loc_addr,
  input  logic [DW-1:0]    loc_wdata,
  output logic [DW-1:0]    loc_rdata,
  input  logic             host_en,
  input  logic             host_we,
  input  logic [AW-1:0]    host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  output logic             lcl_irq,
  output logic             host_irq_n,
  output logic [NPROC-1:0] xirq
);
  import dbmu_pkg::*;

  localparam int unsigned A_IDB  = OFS_IDB;
  localparam int unsigned A_ODB  = OFS_ODB;
  localparam int unsigned A_IMSG = OFS_IMSG;
  localparam int unsigned A_OMSG = ofs_omsg(NMSG);
  localparam int unsigned A_STAT = ofs_stat(NMSG);
  localparam int unsigned A_MASK = ofs_mask(NMSG);
  localparam int unsigned A_CTRL = ofs_ctrl(NMSG);
  localparam int unsigned A_XDB  = ofs_xdb(NMSG);
  localparam int unsigned SW     = NMSG + 1;   // status/mask width

  logic lw, hw;
  assign lw = loc_en & loc_we;
  assign hw = host_en & host_we;

  // control and masks
  logic          en_q, en_nxt;
  logic [SW-1:0] lmask_q, lmask_nxt, hmask_q, hmask_nxt;

  // doorbells
  logic [DW-1:0] idb_set, idb_clr, idb_q, idb_nxt;
  logic [DW-1:0] odb_set, odb_clr, odb_q, odb_nxt;

  // messages
  logic [NMSG-1:0]         imsg_wr, imsg_clr, imsg_pend, imsg_pend_nxt;
  logic [NMSG-1:0]         omsg_wr, omsg_clr, omsg_pend, omsg_pend_nxt;
  logic [NMSG-1:0][DW-1:0] imsg_data, omsg_data;

  // extended doorbells
  logic [NPROC-1:0][DW-1:0] xset, xclr, xdb_q, xdb_nxt;

  // write decode
  always_comb begin
    idb_set  = (hw && en_q && host_addr == AW'(A_IDB)) ? host_wdata : '0;
    idb_clr  = (lw && en_q && loc_addr  == AW'(A_IDB)) ? loc_wdata  : '0;
    odb_set  = (lw && en_q && loc_addr  == AW'(A_ODB)) ? loc_wdata  : '0;
    odb_clr  = (hw && en_q && host_addr == AW'(A_ODB)) ? host_wdata : '0;
    imsg_clr = (lw && en_q && loc_addr  == AW'(A_STAT)) ? loc_wdata[NMSG-1:0]  : '0;
    omsg_clr = (hw && en_q && host_addr == AW'(A_STAT)) ? host_wdata[NMSG-1:0] : '0;
    for (int i = 0; i < NMSG; i++) begin
      imsg_wr[i] = hw && en_q && host_addr == AW'(A_IMSG + i);
      omsg_wr[i] = lw && en_q && loc_addr  == AW'(A_OMSG + i);
    end
    for (int p = 0; p < NPROC; p++) begin
      xset[p] = (lw && !en_q && loc_addr == AW'(A_XDB + 2 * p))     ? loc_wdata : '0;
      xclr[p] = (lw && !en_q && loc_addr == AW'(A_XDB + 2 * p + 1)) ? loc_wdata : '0;
    end
    lmask_nxt = (lw && loc_addr  == AW'(A_MASK)) ? loc_wdata[SW-1:0]  : lmask_q;
    hmask_nxt = (hw && host_addr == AW'(A_MASK)) ? host_wdata[SW-1:0] : hmask_q;
    en_nxt    = (lw && loc_addr  == AW'(A_CTRL)) ? loc_wdata[0] : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b1;
      lmask_q <= '0;
      hmask_q <= '0;
    end else begin
      en_q    <= en_nxt;
      lmask_q <= lmask_nxt;
      hmask_q <= hmask_nxt;
    end
  end

  dbmu_bitreg #(.W(DW)) u_idb (
    .clk(clk), .rst(rst), .set_i(idb_set), .clr_i(idb_clr),
    .q_o(idb_q), .nxt_o(idb_nxt)
  );

  dbmu_bitreg #(.W(DW)) u_odb (
    .clk(clk), .rst(rst), .set_i(odb_set), .clr_i(odb_clr),
    .q_o(odb_q), .nxt_o(odb_nxt)
  );

  dbmu_msgbank #(.DW(DW), .N(NMSG)) u_imsg (
    .clk(clk), .rst(rst), .wr_i(imsg_wr), .wdata_i(host_wdata),
    .clr_i(imsg_clr), .data_o(imsg_data), .pend_o(imsg_pend),
    .pend_nxt_o(imsg_pend_nxt)
  );

  dbmu_msgbank #(.DW(DW), .N(NMSG)) u_omsg (
    .clk(clk), .rst(rst), .wr_i(omsg_wr), .wdata_i(loc_wdata),
    .clr_i(omsg_clr), .data_o(omsg_data), .pend_o(omsg_pend),
    .pend_nxt_o(omsg_pend_nxt)
  );

  dbmu_irq #(.N(SW), .ACTIVE_LOW(1'b0)) u_lirq (
    .clk(clk), .rst(rst), .src_nxt_i({|idb_nxt, imsg_pend_nxt}),
    .mask_nxt_i(lmask_nxt), .enable_nxt_i(en_nxt), .irq_o(lcl_irq)
  );

  dbmu_irq #(.N(SW), .ACTIVE_LOW(1'b1)) u_hirq (
    .clk(clk), .rst(rst), .src_nxt_i({|odb_nxt, omsg_pend_nxt}),
    .mask_nxt_i(hmask_nxt), .enable_nxt_i(en_nxt), .irq_o(host_irq_n)
  );

  for (genvar p = 0; p < NPROC; p++) begin : g_xdb
    dbmu_bitreg #(.W(DW)) u_xdb (
      .clk(clk), .rst(rst), .set_i(xset[p]), .clr_i(xclr[p]),
      .q_o(xdb_q[p]), .nxt_o(xdb_nxt[p])
    );
    dbmu_irq #(.N(1), .ACTIVE_LOW(1'b0)) u_xirq (
      .clk(clk), .rst(rst), .src_nxt_i(|xdb_nxt[p]), .mask_nxt_i(1'b0),
      .enable_nxt_i(~en_nxt), .irq_o(xirq[p])
    );
  end

  // read multiplexers
  logic [DW-1:0] loc_mux, host_mux;

  always_comb begin
    loc_mux = '0;
    if (loc_addr == AW'(A_IDB))  loc_mux = idb_q;
    if (loc_addr == AW'(A_ODB))  loc_mux = odb_q;
    if (loc_addr == AW'(A_STAT)) loc_mux = DW'({|idb_q, imsg_pend});
    if (loc_addr == AW'(A_MASK)) loc_mux = DW'(lmask_q);
    if (loc_addr == AW'(A_CTRL)) loc_mux = DW'(en_q);
    for (int i = 0; i < NMSG; i++) begin
      if (loc_addr == AW'(A_IMSG + i)) loc_mux = imsg_data[i];
      if (loc_addr == AW'(A_OMSG + i)) loc_mux = omsg_data[i];
    end
    for (int p = 0; p < NPROC; p++) begin
      if (loc_addr == AW'(A_XDB + 2 * p) || loc_addr == AW'(A_XDB + 2 * p + 1))
        loc_mux = xdb_q[p];
    end
  end

  always_comb begin
    host_mux = '0;
    if (host_addr == AW'(A_IDB))  host_mux = idb_q;
    if (host_addr == AW'(A_ODB))  host_mux = odb_q;
    if (host_addr == AW'(A_STAT)) host_mux = DW'({|odb_q, omsg_pend});
    if (host_addr == AW'(A_MASK)) host_mux = DW'(hmask_q);
    for (int i = 0; i < NMSG; i++) begin
      if (host_addr == AW'(A_IMSG + i)) host_mux = imsg_data[i];
      if (host_addr == AW'(A_OMSG + i)) host_mux = omsg_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_rdata  <= '0;
      host_rdata <= '0;
    end else begin
      if (loc_en && !loc_we)   loc_rdata  <= loc_mux;
      if (host_en && !host_we) host_rdata <= host_mux;
    end
  end

endmodule

// File: rtl/dbmu_chk.sv
module dbmu_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NMSG  = 2,
  parameter int unsigned NPROC = 2,
  parameter int unsigned AW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             loc_en,
  input logic             loc_we,
  input logic [AW-1:0]    loc_addr,
  input logic [DW-1:0]    loc_wdata,
  input logic             host_en,
  input logic             host_we,
  input logic [AW-1:0]    host_addr,
  input logic [DW-1:0]    host_wdata,
  input logic             lcl_irq,
  input logic             host_irq_n,
  input logic [NPROC-1:0] xirq,
  input logic             en_q,
  input logic [DW-1:0]    idb_q,
  input logic [DW-1:0]    odb_q,
  input logic [NMSG-1:0]  imsg_pend
);
  import dbmu_pkg::*;

  logic lw_idb, hw_idb, lw_odb, hw_odb, hw_imsg0;
  assign lw_idb   = loc_en && loc_we && loc_addr == AW'(OFS_IDB);
  assign hw_idb   = host_en && host_we && host_addr == AW'(OFS_IDB);
  assign lw_odb   = loc_en && loc_we && loc_addr == AW'(OFS_ODB);
  assign hw_odb   = host_en && host_we && host_addr == AW'(OFS_ODB);
  assign hw_imsg0 = host_en && host_we && host_addr == AW'(OFS_IMSG);

  a_r2_idb_set: assert property (@(posedge clk) disable iff (rst)
    (hw_idb && en_q) |=> ((idb_q & $past(host_wdata)) == $past(host_wdata)));

  a_r3_idb_w1c: assert property (@(posedge clk) disable iff (rst)
    (lw_idb && en_q && !hw_idb) |=> ((idb_q & $past(loc_wdata)) == '0));

  a_r5_odb_keep: assert property (@(posedge clk) disable iff (rst)
    (hw_odb && en_q && !lw_odb) |=>
      ((odb_q & ~$past(host_wdata)) == ($past(odb_q) & ~$past(host_wdata))));

  a_r6_imsg_pend: assert property (@(posedge clk) disable iff (rst)
    (hw_imsg0 && en_q) |=> imsg_pend[0]);

  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (host_irq_n && !lcl_irq));

  a_r11_xirq_off: assert property (@(posedge clk) disable iff (rst)
    en_q |-> (xirq == '0));

endmodule

bind dbmu_top dbmu_chk #(.DW(DW), .NMSG(NMSG), .NPROC(NPROC), .AW(AW)) u_chk (
  .clk(clk), .rst(rst),
  .loc_en(loc_en), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
  .host_en(host_en), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
  .lcl_irq(lcl_irq), .host_irq_n(host_irq_n), .xirq(xirq),
  .en_q(en_q), .idb_q(idb_q), .odb_q(odb_q), .imsg_pend(imsg_pend)
);

// File: tb/dbmu_top_tb.sv
`timescale 1ns/1ps
module dbmu_top_tb;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loc_en = 0, loc_we = 0, host_en = 0, host_we = 0;
  logic [AW-1:0] loc_addr = '0, host_addr = '0;
  logic [DW-1:0] loc_wdata = '0, host_wdata = '0;
  logic [DW-1:0] loc_rdata, host_rdata;
  logic lcl_irq, host_irq_n;
  logic [1:0] xirq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dbmu_top u_dut (
    .clk(clk), .rst(rst),
    .loc_en(loc_en), .loc_we(loc_we), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .lcl_irq(lcl_irq), .host_irq_n(host_irq_n), .xirq(xirq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lwr(int a, logic [31:0] d);
    @(negedge clk); loc_en = 1; loc_we = 1; loc_addr = AW'(a); loc_wdata = d;
    @(negedge clk); loc_en = 0; loc_we = 0;
  endtask

  task automatic hwr(int a, logic [31:0] d);
    @(negedge clk); host_en = 1; host_we = 1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk); host_en = 0; host_we = 0;
  endtask

  task automatic lrd(int a, output logic [31:0] d);
    @(negedge clk); loc_en = 1; loc_we = 0; loc_addr = AW'(a);
    @(negedge clk); loc_en = 0; d = loc_rdata;
  endtask

  task automatic hrd(int a, output logic [31:0] d);
    @(negedge clk); host_en = 1; host_we = 0; host_addr = AW'(a);
    @(negedge clk); host_en = 0; d = host_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 lcl_irq", 32'(lcl_irq), 0);
    chk("R1 host_irq_n", 32'(host_irq_n), 1);
    chk("R1 xirq", 32'(xirq), 0);
    lrd(8, d); chk("R1 enable bit", d, 1);
    lrd(0, d); chk("R1 inbound doorbell", d, 0);
    hrd(6, d); chk("R1 host status", d, 0);
  endtask

  task automatic t_idb();
    logic [31:0] d;
    hwr(0, 32'h8000_0001);
    chk("R2 lcl_irq on set", 32'(lcl_irq), 1);
    lrd(0, d); chk("R2 doorbell bits", d, 32'h8000_0001);
    lwr(0, 32'h0000_0001);
    lrd(0, d); chk("R3 clear one bit", d, 32'h8000_0000);
    chk("R3 irq stays", 32'(lcl_irq), 1);
    lwr(0, 32'h0);
    lrd(0, d); chk("R3 zero no effect", d, 32'h8000_0000);
    lwr(0, 32'h8000_0000);
    chk("R3 irq drops", 32'(lcl_irq), 0);
  endtask

  task automatic t_odb();
    logic [31:0] d;
    lwr(1, 32'h0000_00F0);
    chk("R4 host_irq_n low", 32'(host_irq_n), 0);
    hrd(1, d); chk("R4 outbound bits", d, 32'hF0);
    hwr(1, 32'h30);
    hrd(1, d); chk("R5 partial clear", d, 32'hC0);
    chk("R5 irq stays", 32'(host_irq_n), 0);
    hwr(1, 32'h0F);
    hrd(1, d); chk("R5 unset bits no effect", d, 32'hC0);
    hwr(1, 32'hC0);
    chk("R5 host_irq_n high", 32'(host_irq_n), 1);
  endtask

  task automatic t_imsg();
    logic [31:0] d;
    hwr(3, 32'hDEAD_BEEF);
    chk("R6 lcl_irq", 32'(lcl_irq), 1);
    lrd(3, d); chk("R6 local read msg1", d, 32'hDEAD_BEEF);
    lrd(6, d); chk("R6 local status", d, 32'h2);
    lwr(3, 32'h1234);
    hrd(3, d); chk("R6 local write ignored", d, 32'hDEAD_BEEF);
    lwr(6, 32'h1);
    lrd(6, d); chk("R8 other bit kept", d, 32'h2);
    lwr(6, 32'h2);
    lrd(6, d); chk("R8 w1c", d, 32'h0);
    chk("R8 irq drops", 32'(lcl_irq), 0);
  endtask

  task automatic t_omsg();
    logic [31:0] d;
    lwr(4, 32'hA5A5_0001);
    chk("R7 host_irq_n low", 32'(host_irq_n), 0);
    hrd(4, d); chk("R7 host read msg0", d, 32'hA5A5_0001);
    hrd(6, d); chk("R7 host status", d, 32'h1);
    hwr(4, 32'h0);
    lrd(4, d); chk("R7 host write ignored", d, 32'hA5A5_0001);
    hwr(6, 32'h0);
    hrd(6, d); chk("R8 zero no effect", d, 32'h1);
    hwr(6, 32'h1);
    chk("R8 host_irq_n high", 32'(host_irq_n), 1);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    lwr(7, 32'h4);
    hwr(0, 32'h10);
    chk("R9 local masked", 32'(lcl_irq), 0);
    lrd(6, d); chk("R9 status unaffected", d, 32'h4);
    lwr(7, 32'h0);
    chk("R9 unmask raises", 32'(lcl_irq), 1);
    lwr(0, 32'h10);
    hwr(7, 32'h1);
    lwr(4, 32'h77);
    chk("R9 host masked", 32'(host_irq_n), 1);
    hrd(6, d); chk("R9 host status", d, 32'h1);
    hwr(7, 32'h0);
    chk("R9 host unmask", 32'(host_irq_n), 0);
    hwr(6, 32'h1);
    chk("R9 host cleared", 32'(host_irq_n), 1);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk);
    host_en = 1; host_we = 1; host_addr = 0; host_wdata = 32'h1;
    loc_en = 1; loc_we = 1; loc_addr = 0; loc_wdata = 32'h1;
    @(negedge clk); host_en = 0; host_we = 0; loc_en = 0; loc_we = 0;
    lrd(0, d); chk("R3 set wins", d, 32'h1);
    lwr(0, 32'h1);
    @(negedge clk);
    loc_en = 1; loc_we = 0; loc_addr = 0;
    host_en = 1; host_we = 1; host_addr = 0; host_wdata = 32'h4;
    @(negedge clk); loc_en = 0; host_en = 0; host_we = 0;
    chk("R12 old value on same-cycle read", loc_rdata, 32'h0);
    lrd(0, d); chk("R12 new value next read", d, 32'h4);
    lwr(0, 32'h4);
  endtask

  task automatic t_ext();
    logic [31:0] d;
    lwr(9, 32'h1);
    chk("R11 xirq off when enabled", 32'(xirq), 0);
    lrd(9, d); chk("R11 write ignored when enabled", d, 0);
    hwr(0, 32'h1);
    lwr(8, 32'h0);
    chk("R10 lcl_irq forced low", 32'(lcl_irq), 0);
    hwr(0, 32'h2);
    lrd(0, d); chk("R10 write ignored, readable", d, 32'h1);
    lwr(11, 32'h8);
    chk("R11 xirq p1", 32'(xirq), 32'h2);
    lrd(12, d); chk("R11 read via clear offset", d, 32'h8);
    lwr(12, 32'h8);
    chk("R11 p1 cleared", 32'(xirq), 0);
    lwr(9, 32'h3);
    lwr(10, 32'h1);
    chk("R11 partial clear p0", 32'(xirq), 32'h1);
    lrd(9, d); chk("R11 p0 bits", d, 32'h2);
    lwr(8, 32'h1);
    chk("R11 xirq silent after enable", 32'(xirq), 0);
    chk("R10 lcl_irq back", 32'(lcl_irq), 1);
    lwr(0, 32'h1);
    chk("R3 final clear", 32'(lcl_irq), 0);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_idb();
    t_odb();
    t_imsg();
    t_omsg();
    t_mask();
    t_collide();
    t_ext();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule